// File: doc/BRIEF.md
# Exception Trap Prioritizer and Vector Generator

This block sits beside a 16-bit CPU core and collects every request that can divert program flow: three reset sources, three urgent hardware traps (class A), six lower-urgency hardware traps (class B) and the software TRAP instruction with its 7-bit operand. Each cycle it combines the new requests with those still waiting, picks the single most urgent one and issues a one-cycle service strobe. The strobe comes with the vector address to branch to, the trap number, and the interrupt level the core must load.

The three hardware tiers follow different vector rules. All reset sources share vector 0000h and number 00h. Each class A trap has its own vector. All class B causes share one vector, so a sticky flag register records which cause occurred. Software can read that register and clear its bits. A software trap takes its vector from its operand and keeps the current CPU level.

Control is a two-state machine. In `ST_IDLE`, any pending hardware request, or else a software trap request, is serviced and the machine moves to `ST_BUSY`. In `ST_BUSY`, a request of a strictly higher tier preempts the current service and the machine stays in `ST_BUSY`. Otherwise an acknowledge returns the machine to `ST_IDLE`. The tiers, from highest to lowest, are reset, class A, class B and software.

Top module: `exc_prio_vec`

## Requirements
- R1: A request on any bit of `rst_req` (bit 0 hardware, bit 1 software, bit 2 watchdog) is serviced with vector 0000h, number 00h and level 15. It beats every trap requested in the same cycle.
- R2: The class A traps on `a_req` are bit 0 NMI (vector 0008h, number 02h), bit 1 stack overflow (0010h, 04h) and bit 2 stack underflow (0018h, 06h), each at level 15. When several are pending, the lower bit index is serviced first.
- R3: Any `b_req` bit is serviced with vector 0028h, number 0Ah and level 15.
- R4: `trap_flags` holds bits 0..2 for `a_req` bits 0..2 and bits 3..8 for `b_req` bits 0..5. A request sets its bit in the cycle after it is seen, and the bit stays set through later services.
- R5: When `flag_wr` is high, every flag whose `flag_wdata` bit is 0 is cleared and every flag whose bit is 1 is kept. A request in the same cycle sets its flag anyway.
- R6: A software trap is serviced with vector `swt_num`×4 (0000h..01FCh), number `swt_num` and level `cur_ilvl`.
- R7: A software trap request is taken only in `ST_IDLE` with no reset or hardware trap pending or newly requested. Otherwise it is dropped and never serviced later.
- R8: Outputs change in the cycle after the request is seen. `svc_stb` is high for one cycle per service, and the vector, number and level hold their values until the next service.
- R9: While in `ST_BUSY`, a request of the same or a lower tier waits until `ack` returns the block to `ST_IDLE`, and is serviced in the next cycle. A request of a higher tier is serviced at once.
- R10: A hardware service never produces a trap number from 0Bh to 0Fh.
- R11: After reset, `svc_stb` is 0, the vector, number and level are 0, and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block itself |
| rst_req | input | 3 | Reset requests: hardware, software, watchdog |
| a_req | input | 3 | Class A trap requests: NMI, stack overflow, stack underflow |
| b_req | input | 6 | Class B trap requests |
| swt_req | input | 1 | Software trap request |
| swt_num | input | 7 | Software trap number |
| cur_ilvl | input | 4 | Current CPU interrupt level |
| ack | input | 1 | Current service finished |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 9 | Flag write data (0 clears a bit) |
| svc_stb | output | 1 | One-cycle service strobe |
| svc_vec | output | 16 | Vector byte address |
| svc_num | output | 7 | Trap number |
| svc_ilvl | output | 4 | Interrupt level to load |
| trap_flags | output | 9 | Sticky trap flags |

## Verification
The assertions assume that `ack` is raised only while a service is in progress. They also assume that request inputs are valid levels sampled at the clock edge, so a request held for one cycle counts as one event. The stimulus drives each request for exactly one cycle, away from the clock edge. It raises `ack` only after a strobe has been seen, except where the bench checks that `ack` in the idle state does nothing. The flag checks assume that software writes a 1 to every bit it wants to keep, and the stimulus always writes full masks.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        TIER_SW  = 2'd0,
        TIER_B   = 2'd1,
        TIER_A   = 2'd2,
        TIER_RST = 2'd3
    } tier_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;

    localparam logic [15:0] VEC_SHARED_B = 16'h0028;
    localparam logic [6:0]  NUM_SHARED_B = 7'h0A;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int NUM_A  = 3,
    parameter int SWN_W  = 7,
    parameter int ADDR_W = 16
) (
    input  logic              p_rst,
    input  logic [NUM_A-1:0]  p_a,
    input  logic              p_b,
    output logic              hw_any,
    output tier_e             hw_tier,
    output logic [NUM_A-1:0]  a_win,
    output logic [ADDR_W-1:0] hw_vec,
    output logic [SWN_W-1:0]  hw_num
);
    // class A: lowest index has priority
    always_comb begin
        a_win = '0;
        for (int i = NUM_A - 1; i >= 0; i--) begin
            if (p_a[i]) begin
                a_win    = '0;
                a_win[i] = 1'b1;
            end
        end
    end

    always_comb begin
        hw_any  = p_rst | (|p_a) | p_b;
        hw_tier = TIER_SW;
        hw_vec  = '0;
        hw_num  = '0;
        if (p_rst) begin
            hw_tier = TIER_RST;
        end else if (|p_a) begin
            hw_tier = TIER_A;
            for (int i = 0; i < NUM_A; i++) begin
                if (a_win[i]) begin
                    hw_vec = ADDR_W'((i + 1) * 8);
                    hw_num = SWN_W'((i + 1) * 2);
                end
            end
        end else if (p_b) begin
            hw_tier = TIER_B;
            hw_vec  = ADDR_W'(VEC_SHARED_B);
            hw_num  = SWN_W'(NUM_SHARED_B);
        end
    end
endmodule

// File: rtl/exc_flags.sv
module exc_flags #(
    parameter int NUM_FLAGS = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set,
    input  logic                 wr,
    input  logic [NUM_FLAGS-1:0] wdata,
    output logic [NUM_FLAGS-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (wr ? (flags & wdata) : flags) | set;
    end

    // R4: a seen request leaves its flag set
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set)));

    // R4: without a write no flag ever drops
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/exc_prio_vec.sv
module exc_prio_vec
    import exc_pkg::*;
#(
    parameter int NUM_RST = 3,
    parameter int NUM_A   = 3,
    parameter int NUM_B   = 6,
    parameter int SWN_W   = 7,
    parameter int ADDR_W  = 16,
    parameter int ILVL_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_RST-1:0]     rst_req,
    input  logic [NUM_A-1:0]       a_req,
    input  logic [NUM_B-1:0]       b_req,
    input  logic                   swt_req,
    input  logic [SWN_W-1:0]       swt_num,
    input  logic [ILVL_W-1:0]      cur_ilvl,
    input  logic                   ack,
    input  logic                   flag_wr,
    input  logic [NUM_A+NUM_B-1:0] flag_wdata,
    output logic                   svc_stb,
    output logic [ADDR_W-1:0]      svc_vec,
    output logic [SWN_W-1:0]       svc_num,
    output logic [ILVL_W-1:0]      svc_ilvl,
    output logic [NUM_A+NUM_B-1:0] trap_flags
);
    localparam int NUM_FLAGS = NUM_A + NUM_B;
    localparam logic [ILVL_W-1:0] ILVL_MAX = '1;

    state_e state, state_nx;
    tier_e  cur_tier, hw_tier;
    logic   pend_rst, pend_b;
    logic [NUM_A-1:0] pend_a, a_win;
    logic   p_rst, p_b, hw_any;
    logic [NUM_A-1:0] p_a;
    logic [ADDR_W-1:0] hw_vec, sw_vec;
    logic [SWN_W-1:0]  hw_num;
    logic   go, go_hw, svc_hw;

    assign p_rst  = pend_rst | (|rst_req);
    assign p_a    = pend_a | a_req;
    assign p_b    = pend_b | (|b_req);
    assign sw_vec = {{(ADDR_W-SWN_W-2){1'b0}}, swt_num, 2'b00};

    exc_arbiter #(.NUM_A(NUM_A), .SWN_W(SWN_W), .ADDR_W(ADDR_W)) i_arb (
        .p_rst  (p_rst),
        .p_a    (p_a),
        .p_b    (p_b),
        .hw_any (hw_any),
        .hw_tier(hw_tier),
        .a_win  (a_win),
        .hw_vec (hw_vec),
        .hw_num (hw_num)
    );

    exc_flags #(.NUM_FLAGS(NUM_FLAGS)) i_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  ({b_req, a_req}),
        .wr   (flag_wr),
        .wdata(flag_wdata),
        .flags(trap_flags)
    );

    // next state and service decision
    always_comb begin
        state_nx = state;
        go       = 1'b0;
        go_hw    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hw_any) begin
                    go = 1'b1; go_hw = 1'b1; state_nx = ST_BUSY;
                end else if (swt_req) begin
                    go = 1'b1; state_nx = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (hw_any && (hw_tier > cur_tier)) begin
                    go = 1'b1; go_hw = 1'b1;
                end else if (ack) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // pending requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_rst <= 1'b0;
            pend_a   <= '0;
            pend_b   <= 1'b0;
        end else begin
            pend_rst <= p_rst & ~(go_hw && hw_tier == TIER_RST);
            pend_a   <= p_a & ~((go_hw && hw_tier == TIER_A) ? a_win : '0);
            pend_b   <= p_b & ~(go_hw && hw_tier == TIER_B);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_stb  <= 1'b0;
            svc_vec  <= '0;
            svc_num  <= '0;
            svc_ilvl <= '0;
            svc_hw   <= 1'b0;
            cur_tier <= TIER_SW;
        end else begin
            svc_stb <= go;
            if (go) begin
                svc_hw <= go_hw;
                if (go_hw) begin
                    svc_vec  <= hw_vec;
                    svc_num  <= hw_num;
                    svc_ilvl <= ILVL_MAX;
                    cur_tier <= hw_tier;
                end else begin
                    svc_vec  <= sw_vec;
                    svc_num  <= swt_num;
                    svc_ilvl <= cur_ilvl;
                    cur_tier <= TIER_SW;
                end
            end
        end
    end

    // R1: a reset seen in the cycle before a strobe is what gets serviced
    a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_stb && $past(|rst_req)) |->
            (svc_vec == '0 && svc_num == '0 && svc_ilvl == ILVL_MAX));

    // R3: hardware services force the top level
    a_r3_hw_level: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_stb && svc_hw) |-> (svc_ilvl == ILVL_MAX));

    // R10: reserved numbers never come from hardware
    a_r10_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_stb && svc_hw) |-> !(svc_num >= SWN_W'(11) && svc_num <= SWN_W'(15)));

    // R7: a software service only follows a clean idle request
    a_r7_sw_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_stb && !svc_hw) |->
            ($past(swt_req) && $past(state) == ST_IDLE &&
             !$past(|rst_req || |a_req || |b_req)));

    // R9: busy with no hardware waiting gives no new strobe
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !hw_any) |=> !svc_stb);

    // R8: service outputs hold between strobes
    a_r8_hold_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_stb) |-> ($stable(svc_vec) && $stable(svc_num)));
endmodule

// File: tb/test_exc_prio_vec.sv
`timescale 1ns/1ps
module test_exc_prio_vec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rst_req = '0;
    logic [2:0]  a_req = '0;
    logic [5:0]  b_req = '0;
    logic        swt_req = 1'b0;
    logic [6:0]  swt_num = '0;
    logic [3:0]  cur_ilvl = '0;
    logic        ack = 1'b0;
    logic        flag_wr = 1'b0;
    logic [8:0]  flag_wdata = '0;
    logic        svc_stb;
    logic [15:0] svc_vec;
    logic [6:0]  svc_num;
    logic [3:0]  svc_ilvl;
    logic [8:0]  trap_flags;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    exc_prio_vec i_exc_prio_vec (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .a_req(a_req),
        .b_req(b_req), .swt_req(swt_req), .swt_num(swt_num),
        .cur_ilvl(cur_ilvl), .ack(ack), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .svc_stb(svc_stb), .svc_vec(svc_vec),
        .svc_num(svc_num), .svc_ilvl(svc_ilvl), .trap_flags(trap_flags)
    );

    // fields: rst3 a3 b6 sw1 num7 ilvl4 | tag4 estb1 evec16 enum7 eilvl4
    localparam int NV = 19;
    localparam logic [55:0] TBL [NV] = '{
        {3'b001, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd1, 1'b1, 16'h0000, 7'h00, 4'hF},
        {3'b010, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd1, 1'b1, 16'h0000, 7'h00, 4'hF},
        {3'b100, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd1, 1'b1, 16'h0000, 7'h00, 4'hF},
        {3'b000, 3'b001, 6'h00, 1'b0, 7'h00, 4'h0, 4'd2, 1'b1, 16'h0008, 7'h02, 4'hF},
        {3'b000, 3'b010, 6'h00, 1'b0, 7'h00, 4'h0, 4'd2, 1'b1, 16'h0010, 7'h04, 4'hF},
        {3'b000, 3'b100, 6'h00, 1'b0, 7'h00, 4'h0, 4'd2, 1'b1, 16'h0018, 7'h06, 4'hF},
        {3'b000, 3'b000, 6'h01, 1'b0, 7'h00, 4'h0, 4'd3, 1'b1, 16'h0028, 7'h0A, 4'hF},
        {3'b000, 3'b000, 6'h20, 1'b0, 7'h00, 4'h0, 4'd3, 1'b1, 16'h0028, 7'h0A, 4'hF},
        {3'b000, 3'b000, 6'h00, 1'b1, 7'h7F, 4'h3, 4'd6, 1'b1, 16'h01FC, 7'h7F, 4'h3},
        {3'b000, 3'b000, 6'h00, 1'b1, 7'h0C, 4'hF, 4'd6, 1'b1, 16'h0030, 7'h0C, 4'hF},
        {3'b000, 3'b101, 6'h3F, 1'b0, 7'h00, 4'h0, 4'd2, 1'b1, 16'h0008, 7'h02, 4'hF},
        {3'b000, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd2, 1'b1, 16'h0018, 7'h06, 4'hF},
        {3'b000, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd3, 1'b1, 16'h0028, 7'h0A, 4'hF},
        {3'b000, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd9, 1'b0, 16'h0000, 7'h00, 4'h0},
        {3'b100, 3'b001, 6'h00, 1'b1, 7'h11, 4'h2, 4'd1, 1'b1, 16'h0000, 7'h00, 4'hF},
        {3'b000, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd2, 1'b1, 16'h0008, 7'h02, 4'hF},
        {3'b000, 3'b000, 6'h04, 1'b1, 7'h22, 4'h1, 4'd7, 1'b1, 16'h0028, 7'h0A, 4'hF},
        {3'b000, 3'b000, 6'h00, 1'b0, 7'h00, 4'h0, 4'd7, 1'b0, 16'h0000, 7'h00, 4'h0},
        {3'b000, 3'b000, 6'h00, 1'b1, 7'h00, 4'h9, 4'd6, 1'b1, 16'h0000, 7'h00, 4'h9}
    };

    function automatic string rname(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        rst_req = '0; a_req = '0; b_req = '0; swt_req = 1'b0;
        ack = 1'b0; flag_wr = 1'b0;
    endtask

    task automatic svc(input string tag, input logic [15:0] v, input logic [6:0] n,
                       input logic [3:0] l);
        chk({tag, " strobe"}, 32'(svc_stb), 32'd1);
        chk({tag, " vector"}, 32'(svc_vec), 32'(v));
        chk({tag, " number"}, 32'(svc_num), 32'(n));
        chk({tag, " level"},  32'(svc_ilvl), 32'(l));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 strobe", 32'(svc_stb), 32'd0);
        chk("R11 vector", 32'(svc_vec), 32'd0);
        chk("R11 number", 32'(svc_num), 32'd0);
        chk("R11 level",  32'(svc_ilvl), 32'd0);
        chk("R11 flags",  32'(trap_flags), 32'd0);

        for (int k = 0; k < NV; k++) begin
            logic [55:0] e;
            e = TBL[k];
            rst_req  = e[55:53];
            a_req    = e[52:50];
            b_req    = e[49:44];
            swt_req  = e[43];
            swt_num  = e[42:36];
            cur_ilvl = e[35:32];
            tick();
            if (e[27]) svc(rname(e[31:28]), e[26:11], e[10:4], e[3:0]);
            else chk({rname(e[31:28]), " no strobe"}, 32'(svc_stb), 32'd0);
            ack = 1'b1;
            tick();
        end
        // R4 every flag was set by the table and stayed set
        chk("R4 flags accumulated", 32'(trap_flags), 32'h1FF);

        // R5 write 0 to bit 0 only
        flag_wr = 1'b1; flag_wdata = 9'h1FE;
        tick();
        chk("R5 clear one bit", 32'(trap_flags), 32'h1FE);
        // R5 set beats clear; stack overflow also serviced (R2)
        flag_wr = 1'b1; flag_wdata = 9'h000; a_req = 3'b010;
        tick();
        chk("R5 set wins over clear", 32'(trap_flags), 32'h002);
        svc("R2", 16'h0010, 7'h04, 4'hF);
        ack = 1'b1;
        tick();
        tick();
        chk("R4 sticky after idle", 32'(trap_flags), 32'h002);

        // R9 hold and preempt
        b_req = 6'h01;
        tick();
        svc("R9 first B", 16'h0028, 7'h0A, 4'hF);
        b_req = 6'h02;
        tick();
        chk("R9 same tier held", 32'(svc_stb), 32'd0);
        chk("R8 vector held", 32'(svc_vec), 32'h0028);
        a_req = 3'b001;
        tick();
        svc("R9 preempt NMI", 16'h0008, 7'h02, 4'hF);
        a_req = 3'b010;
        tick();
        chk("R9 same tier A held", 32'(svc_stb), 32'd0);
        ack = 1'b1;
        tick();
        chk("R9 ack cycle quiet", 32'(svc_stb), 32'd0);
        tick();
        svc("R9 waiting STKOF", 16'h0010, 7'h04, 4'hF);
        ack = 1'b1;
        tick();
        tick();
        svc("R9 waiting B", 16'h0028, 7'h0A, 4'hF);
        // R7 software trap while busy is dropped
        swt_req = 1'b1; swt_num = 7'h05; cur_ilvl = 4'h4;
        tick();
        chk("R7 sw in busy", 32'(svc_stb), 32'd0);
        ack = 1'b1;
        tick();
        tick();
        chk("R7 sw not replayed", 32'(svc_stb), 32'd0);
        chk("R8 number held", 32'(svc_num), 32'h0A);
        // ack in idle has no effect
        ack = 1'b1;
        tick();
        chk("R8 idle ack no strobe", 32'(svc_stb), 32'd0);

        finish_run();
    end
endmodule